// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a bus-attached peripheral with a file of 16-bit registers. Software reaches it over a simple synchronous register bus with address, write strobe, write data, read strobe and registered read data. Six registers are plain storage with no side effects: mode, data, control, interrupt request, interrupt mask and interrupt status. A power register changes what it stores when one trigger bit is written. A status word is fixed at its reset value.

The GPIO part has a direction register and a level register. The level register can be reached at two word offsets. A bus write to the level register is masked by direction. An external pin event changes single level bits directly, with no direction mask. The 16 output lines carry level AND direction. They are refreshed only when software writes the direction or level register, so pin events alone never move them. Address bits above bit 5 are ignored, which makes the register set repeat every 64 bytes.

Top module: `ctl_gpio_regblk`

## Requirements
- R1: Only address bits [5:0] select a register. Word index addr[5:2] = 0..10 selects mode, data, status, power, control, interrupt request, interrupt mask, interrupt status, direction, level-write and level-read, in that order, and addr[1:0] must be 0. For example, 0x7C4 reaches the data register.
- R2: Write data is cut to its low 16 bits. Mode (0x00), data (0x04), control (0x10), interrupt request (0x14), interrupt mask (0x18) and interrupt status (0x1C) store exactly that value and read it back.
- R3: A write to the power register (0x0C) stores the value. If bit 7 of the value is 1, bits 15 and 6 are also set in the stored word.
- R4: Status (0x08) always reads 0x0002. A write to it changes nothing.
- R5: A write to 0x24 or 0x28 stores (data AND direction) into the level register. Both offsets read the level register.
- R6: A write to direction (0x20) stores the value and leaves the level register unchanged.
- R7: gpio_out equals (level AND direction), latched on the clock edge of any direction or level write, using the values after that write. It is visible after that edge and changes at no other time.
- R8: On an edge where pin_evt_en[n] is 1, level bit n takes pin_evt_val[n], with no direction mask. When this coincides with a level write, the event wins on its own bits and the written value holds on the others. Events alone do not refresh gpio_out.
- R9: A read of an unmapped address returns 0. A write to an unmapped address changes no register, and bad_access is 1 for exactly the one cycle after that write edge.
- R10: bus_rdata is loaded on the edge where bus_ren is 1 and holds until the next read. A read in the same cycle as a write to the same register returns the value from before the write.
- R11: After reset, every register, gpio_out, bad_access and bus_rdata are 0, except status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| pin_evt_en | input | 16 | Per-line pin event strobe |
| pin_evt_val | input | 16 | Per-line pin value for the event |
| gpio_out | output | 16 | Gated GPIO output lines |
| bad_access | output | 1 | One-cycle flag after an unmapped write |

## Verification
Two things can update the level register on the same clock edge: a bus write to a level offset and a pin event. The bench provokes this by driving a zero write to 0x24 together with an event that raises line 0. It then checks that gpio_out and a later readback both show 0x0001, which means the event bit won and the direction mask was not applied to it. A read together with a write to the data register in one cycle is judged the same way: the read must return the old value, and the next read must return the new one.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

   // Low address bits that take part in the decode.
   localparam int DEC_W     = 6;
   localparam int IDX_W     = DEC_W - 2;
   localparam int NUM_PLAIN = 6;

   // The word index in addr[5:2] is this enum's value.
   typedef enum logic [IDX_W-1:0] {
      SEL_MODE   = 4'd0,
      SEL_DATA   = 4'd1,
      SEL_STAT   = 4'd2,
      SEL_PWR    = 4'd3,
      SEL_CTRL   = 4'd4,
      SEL_IRQREQ = 4'd5,
      SEL_IRQMSK = 4'd6,
      SEL_IRQSTS = 4'd7,
      SEL_DIR    = 4'd8,
      SEL_LVLW   = 4'd9,
      SEL_LVLR   = 4'd10,
      SEL_NONE   = 4'd15
   } sel_e;

   localparam int LAST_IDX = 10;

   // Storage slot of a side-effect-free register, or -1.
   function automatic int plain_slot(sel_e s);
      case (s)
         SEL_MODE:   return 0;
         SEL_DATA:   return 1;
         SEL_CTRL:   return 2;
         SEL_IRQREQ: return 3;
         SEL_IRQMSK: return 4;
         SEL_IRQSTS: return 5;
         default:    return -1;
      endcase
   endfunction

endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
   import regblk_pkg::*;
(
   input  logic [DEC_W-1:0] addr,
   output sel_e             sel,
   output logic             mapped
);

   logic [IDX_W-1:0] idx;

   assign idx    = addr[DEC_W-1:2];
   assign mapped = (addr[1:0] == 2'b00) && (int'(idx) <= LAST_IDX);
   assign sel    = mapped ? sel_e'(idx) : SEL_NONE;

endmodule

// File: rtl/regblk_store.sv
module regblk_store
   import regblk_pkg::*;
#(
   parameter int REG_W        = 16,
   parameter int STAT_INIT    = 2,
   parameter int PWR_TRIG_BIT = 7,
   parameter int PWR_FORCE    = 'h8040
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  sel_e             sel,
   input  logic [REG_W-1:0] wr_val,
   output logic [REG_W-1:0] rd_val
);

   localparam logic [REG_W-1:0] FORCE_M = REG_W'(PWR_FORCE);
   localparam logic [REG_W-1:0] STAT_V  = REG_W'(STAT_INIT);

   logic [REG_W-1:0] plain_q [NUM_PLAIN];
   logic [REG_W-1:0] pwr_q;
   logic [REG_W-1:0] pwr_d;

   for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)
            plain_q[k] <= '0;
         else if (wen && plain_slot(sel) == k)
            plain_q[k] <= wr_val;
      end
   end

   assign pwr_d = wr_val | (wr_val[PWR_TRIG_BIT] ? FORCE_M : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pwr_q <= '0;
      else if (wen && sel == SEL_PWR)
         pwr_q <= pwr_d;
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < NUM_PLAIN; k++)
         if (plain_slot(sel) == k) rd_val = plain_q[k];
      if (sel == SEL_STAT) rd_val = STAT_V;
      if (sel == SEL_PWR)  rd_val = pwr_q;
   end

   // R3: trigger bit written -> forced bits present in stored word
   a_r3_pwr_force: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_PWR && wr_val[PWR_TRIG_BIT]) |=> ((pwr_q & FORCE_M) == FORCE_M));

   // R3: without the trigger bit the word is stored as written
   a_r3_pwr_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_PWR && !wr_val[PWR_TRIG_BIT]) |=> (pwr_q == $past(wr_val)));

endmodule

// File: rtl/regblk_gpio.sv
module regblk_gpio
   import regblk_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int NGPIO = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  sel_e             sel,
   input  logic [REG_W-1:0] wr_val,
   input  logic [NGPIO-1:0] evt_en,
   input  logic [NGPIO-1:0] evt_val,
   output logic [REG_W-1:0] rd_val,
   output logic [NGPIO-1:0] gpio_out
);

   logic [REG_W-1:0] dir_q, lvl_q;
   logic [REG_W-1:0] dir_d, lvl_d, lvl_wr_d, gated_d, gated_now;
   logic [NGPIO-1:0] out_q;
   logic             wr_dir, wr_lvl, refresh;

   assign wr_dir  = wen && (sel == SEL_DIR);
   assign wr_lvl  = wen && (sel == SEL_LVLW || sel == SEL_LVLR);
   assign refresh = wr_dir || wr_lvl;

   assign lvl_wr_d = wr_lvl ? (wr_val & dir_q) : lvl_q;
   assign dir_d    = wr_dir ? wr_val : dir_q;

   // Pin events override the bus write bit by bit, with no direction mask.
   for (genvar i = 0; i < REG_W; i++) begin : g_lvl
      if (i < NGPIO) begin : g_pin
         assign lvl_d[i] = evt_en[i] ? evt_val[i] : lvl_wr_d[i];
      end else begin : g_nopin
         assign lvl_d[i] = lvl_wr_d[i];
      end
   end

   assign gated_d   = lvl_d & dir_d;
   assign gated_now = lvl_q & dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         lvl_q <= '0;
         out_q <= '0;
      end else begin
         dir_q <= dir_d;
         lvl_q <= lvl_d;
         if (refresh) out_q <= gated_d[NGPIO-1:0];
      end
   end

   assign gpio_out = out_q;

   always_comb begin
      rd_val = '0;
      if (sel == SEL_DIR)                        rd_val = dir_q;
      else if (sel == SEL_LVLW || sel == SEL_LVLR) rd_val = lvl_q;
   end

   // R7: outputs move only on the edge of a direction or level write
   a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gpio_out) |-> $past(refresh));

   // R7: after a refresh the lines show the gated level
   a_r7_out_match: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |=> (gpio_out == gated_now[NGPIO-1:0]));

   // R5: a bus level write alone leaves no bit outside direction
   a_r5_lvl_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lvl && evt_en == '0) |=> ((lvl_q & ~dir_q) == '0));

   // R8: event bits are loaded unmasked
   a_r8_evt_load: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_en != '0) |=> ((lvl_q[NGPIO-1:0] & $past(evt_en)) == ($past(evt_val) & $past(evt_en))));

   // R6: a direction write leaves level alone
   a_r6_dir_keeps_lvl: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dir && evt_en == '0) |=> (lvl_q == $past(lvl_q)));

endmodule

// File: rtl/ctl_gpio_regblk.sv
module ctl_gpio_regblk
   import regblk_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int BUS_W        = 32,
   parameter int REG_W        = 16,
   parameter int NGPIO        = 16,
   parameter int STAT_INIT    = 2,
   parameter int PWR_TRIG_BIT = 7,
   parameter int PWR_FORCE    = 'h8040
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_ren,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [NGPIO-1:0]  pin_evt_en,
   input  logic [NGPIO-1:0]  pin_evt_val,
   output logic [NGPIO-1:0]  gpio_out,
   output logic              bad_access
);

   initial begin
      assert (ADDR_W > DEC_W)            else $error("ADDR_W must exceed the decoded bits");
      assert (BUS_W > REG_W)             else $error("BUS_W must exceed REG_W");
      assert (NGPIO == REG_W)            else $error("NGPIO must equal REG_W");
      assert (PWR_TRIG_BIT < REG_W)      else $error("PWR_TRIG_BIT out of range");
   end

   sel_e             sel;
   logic             mapped;
   logic [REG_W-1:0] wr_val, store_rd, gpio_rd;
   logic [REG_W-1:0] rdata_q;
   logic             bad_q;
   logic             unused_hi;

   assign wr_val    = bus_wdata[REG_W-1:0];
   assign unused_hi = ^{bus_addr[ADDR_W-1:DEC_W], bus_wdata[BUS_W-1:REG_W]};

   regblk_decode u_dec (
      .addr   (bus_addr[DEC_W-1:0]),
      .sel    (sel),
      .mapped (mapped)
   );

   regblk_store #(
      .REG_W        (REG_W),
      .STAT_INIT    (STAT_INIT),
      .PWR_TRIG_BIT (PWR_TRIG_BIT),
      .PWR_FORCE    (PWR_FORCE)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen    (bus_wen),
      .sel    (sel),
      .wr_val (wr_val),
      .rd_val (store_rd)
   );

   regblk_gpio #(
      .REG_W (REG_W),
      .NGPIO (NGPIO)
   ) u_gpio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (bus_wen),
      .sel      (sel),
      .wr_val   (wr_val),
      .evt_en   (pin_evt_en),
      .evt_val  (pin_evt_val),
      .rd_val   (gpio_rd),
      .gpio_out (gpio_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         bad_q   <= 1'b0;
      end else begin
         if (bus_ren) rdata_q <= store_rd | gpio_rd;
         bad_q <= bus_wen && !mapped;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bad_access = bad_q;

   // R9: flag only after an unmapped write
   a_r9_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(bus_wen && !mapped));

   // R9: unmapped reads return zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && !mapped) |=> (bus_rdata == '0));

   // R4: status reads its fixed value
   a_r4_status_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && sel == SEL_STAT) |=> (bus_rdata == REG_W'(STAT_INIT)));

   // R10: read data holds when no read strobe
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ren |=> $stable(bus_rdata));

endmodule

// File: tb/test_ctl_gpio_regblk.sv
module test_ctl_gpio_regblk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ren = 1'b0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_evt_en = '0;
   logic [15:0] pin_evt_val = '0;
   logic [15:0] gpio_out;
   logic        bad_access;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   ctl_gpio_regblk i_ctl_gpio_regblk (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wen     (bus_wen),
      .bus_wdata   (bus_wdata),
      .bus_ren     (bus_ren),
      .bus_rdata   (bus_rdata),
      .pin_evt_en  (pin_evt_en),
      .pin_evt_val (pin_evt_val),
      .gpio_out    (gpio_out),
      .bad_access  (bad_access)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [31:0] data;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 12'h000, 32'h1234ABCD, 16'h0000},  // R2 truncation
      '{1'b0, 12'h000, 32'h0,        16'hABCD},  // R2
      '{1'b1, 12'h004, 32'h00005A5A, 16'h0000},
      '{1'b0, 12'h044, 32'h0,        16'h5A5A},  // R1 alias
      '{1'b1, 12'h010, 32'h0000FFFF, 16'h0000},
      '{1'b0, 12'h010, 32'h0,        16'hFFFF},  // R2
      '{1'b1, 12'h014, 32'h00000001, 16'h0000},
      '{1'b0, 12'h014, 32'h0,        16'h0001},  // R2
      '{1'b1, 12'h018, 32'h00008000, 16'h0000},
      '{1'b0, 12'h018, 32'h0,        16'h8000},  // R2
      '{1'b1, 12'h01C, 32'h00001357, 16'h0000},
      '{1'b0, 12'h01C, 32'h0,        16'h1357},  // R2
      '{1'b1, 12'h00C, 32'h00000080, 16'h0000},
      '{1'b0, 12'h00C, 32'h0,        16'h80C0},  // R3 forced
      '{1'b1, 12'h00C, 32'h0000F001, 16'h0000},
      '{1'b0, 12'h00C, 32'h0,        16'hF001},  // R3 no force
      '{1'b1, 12'h008, 32'h0000FFFF, 16'h0000},
      '{1'b0, 12'h008, 32'h0,        16'h0002},  // R4
      '{1'b1, 12'h020, 32'h000000FF, 16'h0000},
      '{1'b0, 12'h020, 32'h0,        16'h00FF},  // R6
      '{1'b1, 12'h024, 32'h0000FFFF, 16'h0000},
      '{1'b0, 12'h028, 32'h0,        16'h00FF},  // R5 masked, alias
      '{1'b1, 12'h028, 32'h00000F0F, 16'h0000},
      '{1'b0, 12'h024, 32'h0,        16'h000F},  // R5
      '{1'b0, 12'h02C, 32'h0,        16'h0000},  // R9 unmapped read
      '{1'b0, 12'h002, 32'h0,        16'h0000},  // R9 misaligned
      '{1'b1, 12'h7C4, 32'hABCD0000, 16'h0000},  // R1 high bits ignored
      '{1'b0, 12'h004, 32'h0,        16'h0000}   // R1 R2
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic do_read(input logic [11:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a; bus_ren = 1'b1;
      @(negedge clk);
      bus_ren = 1'b0;
      v = bus_rdata;
   endtask

   initial begin
      logic [15:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 gpio_out", 32'(gpio_out), 32'h0);
      check("R11 bad_access", 32'(bad_access), 32'h0);
      check("R11 rdata", 32'(bus_rdata), 32'h0);
      do_read(12'h00C, rv); check("R11 power", 32'(rv), 32'h0);
      do_read(12'h024, rv); check("R11 level", 32'(rv), 32'h0);
      do_read(12'h008, rv); check("R4 status reset", 32'(rv), 32'h0002);

      for (int n = 0; n < NV; n++) begin
         if (VECS[n].wr) do_write(VECS[n].addr, VECS[n].data);
         else begin
            do_read(VECS[n].addr, rv);
            check($sformatf("vector %0d (R1..R5,R9 table)", n), 32'(rv), 32'(VECS[n].exp));
         end
      end

      // R7: dir 00FF, level 000F
      check("R7 gated out", 32'(gpio_out), 32'h000F);

      // R9 unmapped write pulses flag, stores nothing
      @(negedge clk);
      bus_addr = 12'h03C; bus_wdata = 32'h9999; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      check("R9 bad_access set", 32'(bad_access), 32'h1);
      @(negedge clk);
      check("R9 bad_access one cycle", 32'(bad_access), 32'h0);
      do_read(12'h000, rv); check("R9 mode untouched", 32'(rv), 32'hABCD);
      do_read(12'h024, rv); check("R9 level untouched", 32'(rv), 32'h000F);

      // R8 pin event unmasked, no refresh
      @(negedge clk);
      pin_evt_en = 16'hFF00; pin_evt_val = 16'hFF00;
      @(negedge clk);
      pin_evt_en = '0; pin_evt_val = '0;
      check("R8 no refresh", 32'(gpio_out), 32'h000F);
      do_read(12'h024, rv); check("R8 event unmasked", 32'(rv), 32'hFF0F);

      // R6 R7 direction write refreshes outputs, keeps level
      do_write(12'h020, 32'h0000FFFF);
      check("R7 refresh on dir", 32'(gpio_out), 32'hFF0F);
      do_read(12'h028, rv); check("R6 level kept", 32'(rv), 32'hFF0F);

      // R8 collision: write 0 with event raising line 0
      @(negedge clk);
      bus_addr = 12'h024; bus_wdata = 32'h0; bus_wen = 1'b1;
      pin_evt_en = 16'h0001; pin_evt_val = 16'h0001;
      @(negedge clk);
      bus_wen = 1'b0; pin_evt_en = '0; pin_evt_val = '0;
      check("R8 collision out", 32'(gpio_out), 32'h0001);
      do_read(12'h028, rv); check("R8 collision level", 32'(rv), 32'h0001);

      // R10 same-cycle read and write
      @(negedge clk);
      bus_addr = 12'h004; bus_wdata = 32'h1111; bus_wen = 1'b1; bus_ren = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; bus_ren = 1'b0;
      check("R10 old value", 32'(bus_rdata), 32'h0000);
      do_read(12'h004, rv); check("R10 new value", 32'(rv), 32'h1111);
      repeat (2) @(negedge clk);
      check("R10 hold", 32'(bus_rdata), 32'h1111);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 20000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule